// File: doc/BRIEF.md
# Multi-Mode Display Host Interface

This block is the host-facing bus front end of a display controller. A microcontroller writes bytes to it over one of three bus styles: a 6800-style parallel bus (direction line plus enable strobe), an 8080-style parallel bus (separate active-low write and read strobes), or a two-wire serial link carried on the top two lines of the data bus. A static two-bit input selects the bus style.

Every completed write leaves the block as a single-cycle valid pulse. The pulse carries the received byte and a flag that tells whether the byte is command or display data. A data/command input sets this flag. Reads return the byte on a supplied read-data port, which the block drives onto the bidirectional bus only while a read is in progress.

All host pins are asynchronous to the internal clock. They are brought in through two-flop synchronisers, and strobe edges are detected on the synchronised copies. A pair of chip selects of opposite polarity qualifies every transfer.

Top module: `disp_host_if`

## Requirements
- R1: The chip counts as selected only while `sel_n_i` is 0 and `sel_i` is 1. In any other combination, strobes and serial clocks produce no write pulse and the data bus is not driven.
- R2: A written byte is flagged with `wr_is_data_o` = 1 when `dc_i` is high at capture, and with `wr_is_data_o` = 0 (command) when `dc_i` is low.
- R3: With `mode_i` = 0 (6800), a write is taken when `rw_wrn_i` is 0 and `en_rdn_i` falls after having been high. The byte on `data_io` is captured.
- R4: With `mode_i` = 0 and the chip selected, `data_io` carries `rd_data_i` while `rw_wrn_i` = 1 and `en_rdn_i` = 1.
- R5: With `mode_i` = 1 (8080), a write is taken on the rising edge of the active-low write strobe `rw_wrn_i`.
- R6: With `mode_i` = 1 and the chip selected, `data_io` carries `rd_data_i` while the active-low read strobe `en_rdn_i` is 0.
- R7: With `mode_i` = 2 (serial), `data_io[7]` is serial data and `data_io[6]` is the serial clock. Bits are taken on the rising clock edge, most significant bit first. A byte completes on the eighth bit, and `dc_i` is sampled on that bit.
- R8: Deselecting the chip in serial mode discards any partly received byte. The next byte starts again at its first bit.
- R9: The data bus is high impedance whenever no parallel read is active, and always in serial mode.
- R10: `mode_i` = 3 disables the block. No write pulses are produced and the bus is never driven.
- R11: Each completed write raises `wr_valid_o` for exactly one clock cycle.
- R12: The asynchronous active-low `rst_ni` clears `wr_valid_o`, `wr_byte_o` and `wr_is_data_o` to 0 for any low pulse, even one shorter than a clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bus style: 0 = 6800, 1 = 8080, 2 = serial, 3 = off |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| dc_i | input | 1 | 1 = display data, 0 = command |
| rw_wrn_i | input | 1 | 6800: read (1) or write (0); 8080: active-low write strobe |
| en_rdn_i | input | 1 | 6800: enable strobe; 8080: active-low read strobe |
| data_io | inout | 8 | Parallel data bus; bit 7 = serial data, bit 6 = serial clock in serial mode |
| rd_data_i | input | 8 | Byte returned on reads |
| wr_valid_o | output | 1 | One-cycle pulse per completed write |
| wr_byte_o | output | 8 | Last written byte |
| wr_is_data_o | output | 1 | Data/command flag of the last written byte |

## Verification
The assertions assume that `mode_i` changes only while the chip is deselected and the strobes are idle. They also assume that the data and `dc_i` lines stay stable for several clock cycles around every strobe or serial clock edge, so that the synchronised copies agree when an edge is detected. The bench holds each level for at least three clock cycles, changes mode only after deselecting and settling, and never drives the bus while it expects the block to drive it.

// File: rtl/hif_pkg.sv
package hif_pkg;
  typedef enum logic [1:0] {
    HIF_M68 = 2'd0,
    HIF_I80 = 2'd1,
    HIF_SER = 2'd2,
    HIF_OFF = 2'd3
  } hif_mode_e;

  localparam int unsigned HIF_DW = 8;

  typedef struct packed {
    logic              vld;
    logic              is_data;
    logic [HIF_DW-1:0] val;
  } hif_wr_t;
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hif_par.sv
module hif_par
  import hif_pkg::*;
#(
  parameter int unsigned DW = HIF_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hif_mode_e     mode_i,
  input  logic          sel_s_i,
  input  logic          dc_s_i,
  input  logic          rw_s_i,
  input  logic          en_s_i,
  input  logic [DW-1:0] dat_s_i,
  output hif_wr_t       wr_o
);
  logic en_q, rw_q;
  logic fire_68, fire_80;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      rw_q <= 1'b1;
    end else begin
      en_q <= en_s_i;
      rw_q <= rw_s_i;
    end
  end

  // 6800: latch on enable fall with R/W low; 8080: latch on write strobe release
  assign fire_68 = (mode_i == HIF_M68) && sel_s_i && en_q && !en_s_i && !rw_s_i;
  assign fire_80 = (mode_i == HIF_I80) && sel_s_i && !rw_q && rw_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o <= '0;
    end else begin
      wr_o.vld <= fire_68 || fire_80;
      if (fire_68 || fire_80) begin
        wr_o.val     <= dat_s_i;
        wr_o.is_data <= dc_s_i;
      end
    end
  end

  a_r3_m68_fall_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o.vld && mode_i == HIF_M68) |-> ($past(en_q) && !$past(en_s_i)));
  a_r5_i80_rise_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o.vld && mode_i == HIF_I80) |-> (!$past(rw_q) && $past(rw_s_i)));
endmodule

// File: rtl/hif_ser.sv
module hif_ser
  import hif_pkg::*;
#(
  parameter int unsigned DW = HIF_DW
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    act_i,
  input  logic    sel_s_i,
  input  logic    dc_s_i,
  input  logic    sck_s_i,
  input  logic    sda_s_i,
  output hif_wr_t wr_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic          rise;

  assign rise = sck_s_i && !sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      wr_o  <= '0;
    end else begin
      sck_q    <= sck_s_i;
      wr_o.vld <= 1'b0;
      if (!act_i || !sel_s_i) begin
        cnt_q <= '0;
      end else if (rise) begin
        sh_q <= {sh_q[DW-2:0], sda_s_i};
        if (cnt_q == LAST) begin
          cnt_q        <= '0;
          wr_o.vld     <= 1'b1;
          wr_o.val     <= {sh_q[DW-2:0], sda_s_i};
          wr_o.is_data <= dc_s_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r8_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s_i |=> (cnt_q == '0));
  a_r7_eighth_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o.vld |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
  import hif_pkg::*;
#(
  parameter int unsigned DW     = HIF_DW,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          sel_n_i,
  input  logic          sel_i,
  input  logic          dc_i,
  input  logic          rw_wrn_i,
  input  logic          en_rdn_i,
  inout  wire  [DW-1:0] data_io,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_byte_o,
  output logic          wr_is_data_o
);
  localparam int unsigned SW      = DW + 4;
  localparam int unsigned SDA_BIT = DW - 1;
  localparam int unsigned SCK_BIT = DW - 2;
  // sel, dc, rw/wrn, en/rdn, data
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, 1'b0, {DW{1'b0}}};

  hif_mode_e mode;
  logic [SW-1:0] raw_in, syn;
  logic sel_raw, sel_s, dc_s, rw_s, en_s;
  logic [DW-1:0] dat_s;
  logic oe;
  hif_wr_t par_wr, ser_wr;

  assign mode    = hif_mode_e'(mode_i);
  assign sel_raw = !sel_n_i && sel_i;
  assign raw_in  = {sel_raw, dc_i, rw_wrn_i, en_rdn_i, data_io};

  hif_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (syn)
  );

  assign {sel_s, dc_s, rw_s, en_s, dat_s} = syn;

  hif_par #(.DW(DW)) u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .sel_s_i (sel_s),
    .dc_s_i  (dc_s),
    .rw_s_i  (rw_s),
    .en_s_i  (en_s),
    .dat_s_i (dat_s),
    .wr_o    (par_wr)
  );

  hif_ser #(.DW(DW)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (mode == HIF_SER),
    .sel_s_i (sel_s),
    .dc_s_i  (dc_s),
    .sck_s_i (dat_s[SCK_BIT]),
    .sda_s_i (dat_s[SDA_BIT]),
    .wr_o    (ser_wr)
  );

  // bus drive from raw pins so read data follows the strobe without sync delay
  always_comb begin
    unique case (mode)
      HIF_M68: oe = sel_raw && rw_wrn_i && en_rdn_i;
      HIF_I80: oe = sel_raw && !en_rdn_i;
      default: oe = 1'b0;
    endcase
  end

  assign data_io = oe ? rd_data_i : {DW{1'bz}};

  always_comb begin
    if (mode == HIF_SER) begin
      wr_valid_o   = ser_wr.vld;
      wr_byte_o    = ser_wr.val;
      wr_is_data_o = ser_wr.is_data;
    end else begin
      wr_valid_o   = par_wr.vld;
      wr_byte_o    = par_wr.val;
      wr_is_data_o = par_wr.is_data;
    end
  end

  always_comb begin
    if (mode_i == 2'd2 || mode_i == 2'd3) a_r9_no_drive: assert (!oe);
  end

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  a_r1_write_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(sel_s));
  a_r10_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> !wr_valid_o);
endmodule

// File: tb/sim_disp_host_if.sv
`timescale 1ns/1ps
module sim_disp_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sel_n = 1'b1, sel = 1'b0, dc = 1'b0, rwp = 1'b1, enp = 1'b0;
  logic [7:0] drv = '0, rd_data = '0;
  logic drv_en = 1'b0;
  wire  [7:0] data_io;
  logic wr_valid, wr_is_data;
  logic [7:0] wr_byte;

  int n_chk = 0, n_err = 0, n_wr = 0, exp_wr = 0;
  logic [7:0] last_b = '0;
  logic last_dc = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign data_io = drv_en ? drv : 8'bz;

  disp_host_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sel_n_i(sel_n), .sel_i(sel),
    .dc_i(dc), .rw_wrn_i(rwp), .en_rdn_i(enp), .data_io(data_io),
    .rd_data_i(rd_data), .wr_valid_o(wr_valid), .wr_byte_o(wr_byte),
    .wr_is_data_o(wr_is_data)
  );

  always @(negedge clk) if (rst_n && wr_valid) begin
    n_wr++;
    last_b  = wr_byte;
    last_dc = wr_is_data;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit combo_sel(input logic sn, input logic s);
    return !sn && s;
  endfunction

  task automatic set_sel(input int k);
    case (k)
      0: begin sel_n = 1'b1; sel = 1'b1; end
      1: begin sel_n = 1'b0; sel = 1'b0; end
      2: begin sel_n = 1'b1; sel = 1'b0; end
      default: begin sel_n = 1'b0; sel = 1'b1; end
    endcase
  endtask

  task automatic set_mode(input logic [1:0] m);
    sel_n = 1'b1; sel = 1'b0; drv_en = 1'b1; drv = 8'h00;
    mode = m; rwp = 1'b1;
    enp = (m == 2'd1) ? 1'b1 : 1'b0;
    cyc(6);
  endtask

  task automatic w68(input logic d, input logic [7:0] b);
    dc = d; drv = b; drv_en = 1'b1; rwp = 1'b0; cyc(3);
    enp = 1'b1; cyc(4); enp = 1'b0; cyc(4); rwp = 1'b1; cyc(3);
  endtask

  task automatic w80(input logic d, input logic [7:0] b);
    dc = d; drv = b; drv_en = 1'b1; cyc(3);
    rwp = 1'b0; cyc(4); rwp = 1'b1; cyc(4);
  endtask

  task automatic wser(input logic d, input logic [7:0] b, input int nbits);
    dc = d; drv_en = 1'b1;
    for (int i = 7; i > 7 - nbits; i--) begin
      drv = {b[i], 1'b0, 6'b0}; cyc(3);
      drv = {b[i], 1'b1, 6'b0}; cyc(3);
    end
    drv = 8'h00; cyc(3);
  endtask

  // parallel read: check drive when selected, otherwise bus keeps bench pattern
  task automatic rd_par(input logic [1:0] m, input string tag);
    logic s;
    logic [7:0] pat;
    s = combo_sel(sel_n, sel) && (m != 2'd2) && (m != 2'd3);
    rd_data = 8'($urandom);
    pat = ~rd_data;
    drv_en = !s; drv = pat;
    if (m == 2'd1) enp = 1'b0; else begin rwp = 1'b1; enp = 1'b1; end
    cyc(2);
    if (s) chk(data_io === rd_data, tag, int'(data_io), int'(rd_data));
    else   chk(data_io === pat, tag, int'(data_io), int'(pat));
    enp = (m == 2'd1) ? 1'b1 : 1'b0; cyc(3);
    drv_en = 1'b1; drv = 8'h00; cyc(2);
  endtask

  task automatic do_write(input logic [1:0] m, input logic d, input logic [7:0] b, input string tag);
    bit s;
    s = combo_sel(sel_n, sel) && (m != 2'd3);
    if (m == 2'd0) w68(d, b);
    else if (m == 2'd1) w80(d, b);
    else wser(d, b, 8);
    cyc(6);
    if (s) exp_wr++;
    chk(n_wr == exp_wr, {tag, " count"}, n_wr, exp_wr);
    if (s) begin
      chk(last_b == b, {tag, " byte"}, int'(last_b), int'(b));
      chk(last_dc == d, {tag, " R2 flag"}, int'(last_dc), int'(d));
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1811);
    drv_en = 1'b1;
    cyc(3);
    // R12 reset state
    chk(wr_valid == 1'b0 && wr_byte == 8'h00 && wr_is_data == 1'b0, "R12 reset state",
        {wr_valid, wr_byte, wr_is_data}, 0);
    rst_n = 1'b1;
    cyc(4);

    // R3 / R2 directed 6800 writes
    set_mode(2'd0); set_sel(3);
    do_write(2'd0, 1'b0, 8'h3C, "R3 m68 cmd");
    do_write(2'd0, 1'b1, 8'hC3, "R3 m68 data");
    rd_par(2'd0, "R4 m68 read");
    // R1 each invalid select combination
    for (int k = 0; k < 3; k++) begin
      set_sel(k);
      do_write(2'd0, 1'b1, 8'h55, "R1 m68 deselected");
      rd_par(2'd0, "R1 no drive deselected");
    end
    // R5 / R6 8080
    set_mode(2'd1); set_sel(3);
    do_write(2'd1, 1'b1, 8'hA1, "R5 i80 data");
    do_write(2'd1, 1'b0, 8'h7E, "R5 i80 cmd");
    rd_par(2'd1, "R6 i80 read");
    // R7 serial, R9 no drive in serial
    set_mode(2'd2); set_sel(3);
    do_write(2'd2, 1'b1, 8'h96, "R7 ser data");
    do_write(2'd2, 1'b0, 8'h01, "R7 ser cmd");
    enp = 1'b1; rwp = 1'b1; drv_en = 1'b1; drv = 8'h5A; cyc(2);
    chk(data_io === 8'h5A, "R9 serial no drive", int'(data_io), 8'h5A);
    enp = 1'b0; drv = 8'h00; cyc(3);
    // R8 partial byte then deselect
    wser(1'b1, 8'hF0, 5);
    set_sel(2); cyc(4); set_sel(3); cyc(4);
    do_write(2'd2, 1'b1, 8'h2D, "R8 ser after abort");
    // R10 off mode
    set_mode(2'd3); set_sel(3);
    enp = 1'b0;
    w68(1'b1, 8'hEE); w80(1'b0, 8'hDD); wser(1'b1, 8'hCC, 8); cyc(6);
    chk(n_wr == exp_wr, "R10 off no writes", n_wr, exp_wr);
    rd_par(2'd3, "R10 off no drive");
    // R12 short async reset pulse
    set_mode(2'd0); set_sel(3);
    do_write(2'd0, 1'b1, 8'hB7, "R11 pre-reset write");
    #1 rst_n = 1'b0; #1 rst_n = 1'b1;
    cyc(1);
    chk(wr_byte == 8'h00 && wr_is_data == 1'b0, "R12 short pulse clears",
        {wr_byte, wr_is_data}, 0);

    // constrained random mix
    for (int it = 0; it < 150; it++) begin
      logic [1:0] m;
      m = 2'($urandom % 3);
      set_mode(m);
      set_sel(($urandom % 5 < 3) ? 3 : int'($urandom % 3));
      if (m != 2'd2 && ($urandom % 4 == 0)) rd_par(m, "R4/R6 random read");
      else do_write(m, 1'($urandom), 8'($urandom), "R11 random write");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule